// File: doc/BRIEF.md
# Two-Cycle DMA Transfer Sequencer

This block moves a programmed number of 8-bit or 16-bit units from one memory region to another. Each unit has a read phase and a write phase. The read phase fetches the unit from the source into a 16-bit holding register. The write phase delivers the held unit to the destination. Exactly one idle clock always separates the two phases.

Every region has a fixed bus width, which the block works out from the top two address bits. When the source or destination is only 8 bits wide, a 16-bit unit is carried as two byte accesses, lower byte first. When both sides are at least 16 bits wide, one access per phase is enough. In that case the lane of a 32-bit region is chosen by address bit 1.

Software sets the addresses, the unit size and the count, then pulses `start`. The block steps both addresses after every unit and pulses `done` when the last unit has been written.

Top module: `dma2c_seq`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `bus_req` and `bus_we` are low.
- R2: A read phase drives the current source address with `bus_we` low. A write phase drives the current destination address with `bus_we` high. The bytes read from the source end up at the destination unchanged.
- R3: Between the last read of a unit and the first write of that unit there is exactly one clock with `bus_req` low.
- R4: Region width comes from address bits [31:30]. The value 11 is the peripheral space (16 bits) and 10 is internal RAM (32 bits). Any other value is external memory, which is 16 bits when `ext_wide` is 1 and 8 bits when it is 0.
- R5: A 16-bit unit from an 8-bit source is read as two consecutive byte accesses at a and a+1, followed by one halfword write. The byte from a becomes the low byte.
- R6: A 16-bit unit to an 8-bit destination is read as one halfword and written as two consecutive byte accesses. The low byte goes to the even address first and the high byte to address+1. A halfword access always uses an even address.
- R7: A 16-bit unit between regions of 16 or 32 bits uses one halfword read and one halfword write. `bus_half` equals address bit 1 for a 32-bit region and is 0 otherwise.
- R8: `bus_size` is 0 for a byte access and 1 for a halfword access. A byte unit uses exactly one byte read and one byte write. Byte data travels on bits [7:0]: read bits [15:8] are ignored and write bits [15:8] are zero.
- R9: After each unit, both addresses advance by 1 for byte units or 2 for halfword units. `xfer_cnt` units are moved in total.
- R10: `done` is high for exactly one clock after the final write is accepted. A count of zero gives that pulse on the clock after `start`, with no bus access.
- R11: While `bus_rdy` is low, the current phase is held and `bus_addr`, `bus_we` and `bus_size` do not change.
- R12: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a transfer when idle |
| unit16 | input | 1 | Unit size: 1 = 16 bits, 0 = 8 bits |
| ext_wide | input | 1 | External memory width: 1 = 16 bits, 0 = 8 bits |
| src_addr | input | AW | First source address |
| dst_addr | input | AW | First destination address |
| xfer_cnt | input | CW | Number of units |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock completion pulse |
| bus_addr | output | AW | Bus address |
| bus_req | output | 1 | Bus phase active |
| bus_we | output | 1 | 1 = write phase, 0 = read phase |
| bus_size | output | 1 | 1 = halfword, 0 = byte |
| bus_half | output | 1 | Lane select of a 32-bit region |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_rdy | input | 1 | Phase completes on a clock where this is high |

## Verification
The hardest situation to reach is a halfword unit split into bytes while the bus inserts wait states. In that case the byte index, the held address and the write-phase gap all have to survive several stalled clocks. The bench sets up this situation with a bus model that holds `bus_rdy` low for a programmed number of clocks on every phase, for both directions of byte splitting. It then compares the destination bytes, the per-phase address stability and the idle gap. A second start pulse during a running transfer shows that a launch attempt while busy leaves the count and addresses alone.

// File: rtl/dma2c_pkg.sv
package dma2c_pkg;
    typedef enum logic [1:0] {BW8 = 2'd0, BW16 = 2'd1, BW32 = 2'd2} bw_e;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_GAP = 2'd2, ST_WR = 2'd3} st_e;
endpackage

// File: rtl/dma2c_region.sv
module dma2c_region
    import dma2c_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic          ext_wide,
    output bw_e           bw
);
    always_comb begin
        unique case (addr[AW-1:AW-2])
            2'b11:   bw = BW16;
            2'b10:   bw = BW32;
            default: bw = ext_wide ? BW16 : BW8;
        endcase
    end
endmodule

// File: rtl/dma2c_lane.sv
module dma2c_lane #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] hold_q,
    input  logic [DW-1:0] rdata,
    input  logic          idx,
    input  logic          u16,
    input  logic          split_rd,
    input  logic          split_wr,
    output logic [DW-1:0] cap,
    output logic [DW-1:0] wdata
);
    localparam int BYTE = DW / 2;

    always_comb begin
        if (split_rd)
            cap = idx ? {rdata[BYTE-1:0], hold_q[BYTE-1:0]}
                      : {hold_q[DW-1:BYTE], rdata[BYTE-1:0]};
        else if (u16)
            cap = rdata;
        else
            cap = {{BYTE{1'b0}}, rdata[BYTE-1:0]};

        if (split_wr)
            wdata = {{BYTE{1'b0}}, idx ? hold_q[DW-1:BYTE] : hold_q[BYTE-1:0]};
        else if (u16)
            wdata = hold_q;
        else
            wdata = {{BYTE{1'b0}}, hold_q[BYTE-1:0]};
    end
endmodule

// File: rtl/dma2c_seq.sv
module dma2c_seq
    import dma2c_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          unit16,
    input  logic          ext_wide,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [CW-1:0] xfer_cnt,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] bus_addr,
    output logic          bus_req,
    output logic          bus_we,
    output logic          bus_size,
    output logic          bus_half,
    output logic [15:0]   bus_wdata,
    input  logic [15:0]   bus_rdata,
    input  logic          bus_rdy
);
    localparam int DW    = 16;
    localparam int NSIDE = 2;

    typedef struct packed {
        st_e           st;
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic          idx;
        logic          u16;
        logic          ew;
        logic [DW-1:0] hold;
        logic          done;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NSIDE-1:0][AW-1:0] side_addr;
    bw_e                      side_bw [NSIDE];

    assign side_addr[0] = seq_q.src;
    assign side_addr[1] = seq_q.dst;

    for (genvar g = 0; g < NSIDE; g++) begin : g_region
        dma2c_region #(.AW(AW)) u_region (
            .addr     (side_addr[g]),
            .ext_wide (seq_q.ew),
            .bw       (side_bw[g])
        );
    end

    logic          split_rd, split_wr, in_wr;
    logic [AW-1:0] step;
    logic [DW-1:0] cap_data;
    bw_e           cur_bw;

    assign split_rd = seq_q.u16 && (side_bw[0] == BW8);
    assign split_wr = seq_q.u16 && (side_bw[1] == BW8);
    assign in_wr    = (seq_q.st == ST_WR);
    assign step     = seq_q.u16 ? AW'(2) : AW'(1);

    dma2c_lane #(.DW(DW)) u_lane (
        .hold_q   (seq_q.hold),
        .rdata    (bus_rdata),
        .idx      (seq_q.idx),
        .u16      (seq_q.u16),
        .split_rd (split_rd),
        .split_wr (split_wr),
        .cap      (cap_data),
        .wdata    (bus_wdata)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.src  = src_addr;
                    seq_d.dst  = dst_addr;
                    seq_d.cnt  = xfer_cnt;
                    seq_d.u16  = unit16;
                    seq_d.ew   = ext_wide;
                    seq_d.idx  = 1'b0;
                    if (xfer_cnt == '0) seq_d.done = 1'b1;
                    else                seq_d.st   = ST_RD;
                end
            end
            ST_RD: begin
                if (bus_rdy) begin
                    seq_d.hold = cap_data;
                    if (split_rd && !seq_q.idx) begin
                        seq_d.idx = 1'b1;
                    end else begin
                        seq_d.idx = 1'b0;
                        seq_d.st  = ST_GAP;
                    end
                end
            end
            ST_GAP: seq_d.st = ST_WR;
            ST_WR: begin
                if (bus_rdy) begin
                    if (split_wr && !seq_q.idx) begin
                        seq_d.idx = 1'b1;
                    end else begin
                        seq_d.idx = 1'b0;
                        seq_d.src = seq_q.src + step;
                        seq_d.dst = seq_q.dst + step;
                        seq_d.cnt = seq_q.cnt - CW'(1);
                        if (seq_q.cnt == CW'(1)) begin
                            seq_d.done = 1'b1;
                            seq_d.st   = ST_IDLE;
                        end else begin
                            seq_d.st   = ST_RD;
                        end
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy     = (seq_q.st != ST_IDLE);
    assign done     = seq_q.done;
    assign bus_req  = (seq_q.st == ST_RD) || in_wr;
    assign bus_we   = in_wr;
    assign bus_addr = (in_wr ? seq_q.dst : seq_q.src) + AW'(seq_q.idx);
    assign cur_bw   = in_wr ? side_bw[1] : side_bw[0];
    assign bus_size = seq_q.u16 && !(in_wr ? split_wr : split_rd);
    assign bus_half = (cur_bw == BW32) && bus_addr[1];
endmodule

// File: rtl/dma2c_chk.sv
module dma2c_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          bus_req,
    input logic          bus_we,
    input logic          bus_size,
    input logic          bus_rdy,
    input logic [AW-1:0] bus_addr
);
    p_hold_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size));

    p_one_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_we) |-> !$past(bus_req) && $past(bus_req, 2) && !$past(bus_we, 2));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_half_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_size |-> !bus_addr[0]);

    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req && !bus_we);
endmodule

bind dma2c_seq dma2c_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_size (bus_size),
    .bus_rdy  (bus_rdy),
    .bus_addr (bus_addr)
);

// File: tb/tb_dma2c_seq.sv
module tb_dma2c_seq;
    localparam int CLK_NS = 10;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic        u16;
        logic        ew;
        logic [3:0]  cnt;
        logic [1:0]  wt;
        logic [3:0]  erd;
        logic [3:0]  ewr;
        logic [3:0]  ebo;
    } vec_t;

    // R4 widths: C=periph16, 8=RAM32, 0=external (ew picks 8/16)
    localparam vec_t TBL [7] = '{
        '{32'hC000_0010, 32'h8000_0080, 1'b1, 1'b0, 4'd2, 2'd0, 4'd2, 4'd2, 4'd0},
        '{32'h8000_0012, 32'hC000_0084, 1'b1, 1'b0, 4'd2, 2'd1, 4'd2, 4'd2, 4'd0},
        '{32'h0000_0020, 32'h8000_0090, 1'b1, 1'b0, 4'd2, 2'd0, 4'd4, 4'd2, 4'd4},
        '{32'h8000_0030, 32'h0000_00A0, 1'b1, 1'b0, 4'd2, 2'd2, 4'd2, 4'd4, 4'd4},
        '{32'h0000_0040, 32'hC000_00B1, 1'b0, 1'b0, 4'd3, 2'd1, 4'd3, 4'd3, 4'd6},
        '{32'h0000_0050, 32'h0000_00C0, 1'b1, 1'b1, 4'd1, 2'd0, 4'd1, 4'd1, 4'd0},
        '{32'h0000_0060, 32'h0000_00D0, 1'b1, 1'b0, 4'd1, 2'd3, 4'd2, 4'd2, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        unit16 = 1'b0;
    logic        ext_wide = 1'b0;
    logic [31:0] src_addr = '0;
    logic [31:0] dst_addr = '0;
    logic [15:0] xfer_cnt = '0;
    logic        busy, done, bus_req, bus_we, bus_size, bus_half;
    logic [31:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_rdy = 1'b0;

    dma2c_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .unit16(unit16), .ext_wide(ext_wide),
        .src_addr(src_addr), .dst_addr(dst_addr), .xfer_cnt(xfer_cnt),
        .busy(busy), .done(done), .bus_addr(bus_addr), .bus_req(bus_req),
        .bus_we(bus_we), .bus_size(bus_size), .bus_half(bus_half),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
    );

    always #(CLK_NS/2) clk = ~clk;

    logic [7:0] mem [256];
    int n_chk = 0, n_bad = 0;
    int waits = 0, wcnt = 0;
    int n_rd, n_wr, n_bo, n_done, n_gap, gap_err, half_err, stab_err, gap;
    bit rd_pend = 0, holding = 0, h_we = 0;
    logic [31:0] h_addr = '0;

    // bus model and monitor, all at the falling edge
    always @(negedge clk) begin
        logic [7:0] a, a1;
        a  = bus_addr[7:0];
        a1 = a + 8'd1;
        if (done) n_done++;
        if (bus_req) begin
            if (holding && (bus_addr != h_addr || bus_we != h_we)) stab_err++;
            if (bus_we && rd_pend) begin
                n_gap++;
                if (gap != 1) gap_err++;
                rd_pend = 0;
            end
            if (wcnt < waits) begin
                bus_rdy = 1'b0; wcnt++; holding = 1; h_addr = bus_addr; h_we = bus_we;
            end else begin
                bus_rdy = 1'b1; wcnt = 0; holding = 0;
                if (!bus_size) n_bo++;
                if (bus_half != ((bus_addr[31:30] == 2'b10) && bus_addr[1])) half_err++;
                if (bus_we) begin
                    n_wr++;
                    mem[a] = bus_wdata[7:0];
                    if (bus_size) mem[a1] = bus_wdata[15:8];
                    else if (bus_wdata[15:8] != 8'h00) half_err++;
                end else begin
                    n_rd++; rd_pend = 1; gap = 0;
                end
            end
            bus_rdata = bus_size ? {mem[a1], mem[a]} : {8'hEE, mem[a]};
        end else begin
            bus_rdy = 1'b0; holding = 0;
            if (rd_pend) gap++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic clear();
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        n_rd = 0; n_wr = 0; n_bo = 0; n_done = 0; n_gap = 0;
        gap_err = 0; half_err = 0; stab_err = 0; gap = 0; rd_pend = 0;
    endtask

    task automatic run(input vec_t v, input bit poke);
        bit seen = 0;
        int nb;
        clear();
        waits = int'(v.wt);
        src_addr = v.src; dst_addr = v.dst; unit16 = v.u16; ext_wide = v.ew;
        xfer_cnt = 16'(v.cnt); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            src_addr = 32'h0000_0070; dst_addr = 32'h0000_00F0; xfer_cnt = 16'd5; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int k = 0; k < 3000 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk(seen, "R10 done seen", int'(seen), 1);
        @(negedge clk);
        chk(!done && !busy, "R10 done one clock", int'(done), 0);
        chk(n_done == 1, "R10 done count", n_done, 1);
        chk(n_rd == int'(v.erd), poke ? "R12 reads" : "R5 R7 R8 reads", n_rd, int'(v.erd));
        chk(n_wr == int'(v.ewr), poke ? "R12 writes" : "R6 R7 R8 writes", n_wr, int'(v.ewr));
        chk(n_bo == int'(v.ebo), "R8 byte accesses", n_bo, int'(v.ebo));
        chk(n_gap == int'(v.cnt) && gap_err == 0, "R3 idle gap", gap_err, 0);
        chk(half_err == 0, "R7 lane select", half_err, 0);
        chk(stab_err == 0, "R11 hold stable", stab_err, 0);
        nb = int'(v.cnt) * (v.u16 ? 2 : 1);
        for (int i = 0; i < nb; i++) begin
            logic [7:0] sb, db;
            sb = v.src[7:0] + 8'(i);
            db = v.dst[7:0] + 8'(i);
            chk(mem[db] == 8'(sb * 7 + 3), "R2 R9 dest data", int'(mem[db]), int'(8'(sb * 7 + 3)));
        end
        chk(mem[8'h75] == 8'(8'h75 * 7 + 3) && mem[8'hF0] == 8'(8'hF0 * 7 + 3) || !poke,
            "R12 start while busy", int'(mem[8'hF0]), int'(8'(8'hF0 * 7 + 3)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R10 watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        clear();
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bus_req && !bus_we, "R1 in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !bus_req, "R1 after reset", int'(bus_req), 0);

        for (int t = 0; t < 7; t++) run(TBL[t], 1'b0);

        // R12: second start during a split transfer with waits
        run(TBL[6], 1'b1);

        // R10: zero count
        clear();
        xfer_cnt = 16'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(done == 1'b1, "R10 zero count pulse", int'(done), 1);
        chk(n_rd + n_wr == 0, "R10 zero count no access", n_rd + n_wr, 0);
        @(negedge clk);
        chk(!done && !busy, "R10 zero count ends", int'(done), 0);

        report();
    end
endmodule